// File: doc/BRIEF.md
# Serial Capacitor Trim Control Logic

This block is the digital core of a tuning capacitor that is trimmed over a three-wire serial link. An 11-bit control word arrives one bit at a time on a data line, with each bit taken on a rising edge of a serial clock line. The level at which the serial clock line rests then picks the source of the capacitor selects. When the line rests high, the freshly shifted word drives the selects directly and a 1 turns a capacitor on. When the line rests low, the selects come from a modelled nonvolatile word, and a stored 0 turns a capacitor on.

A programming-voltage pulse flag acts on the nonvolatile word. The shifted word present during the pulse decides what the pulse does. All ones erases the word. Exactly one zero clears the matching stored bit. Any other pattern does nothing. A pulse that is too short also does nothing. For readback, the bit chosen by a single zero in the shifted word is reported on a read level output while data and clock both rest high.

The serial inputs are sampled by a block clock. A variant input selects between a three-field decode (coarse, mid, fine) and a reduced two-field decode.

Top module: `trim_ctrl`

## Requirements
- R1: Each rising edge of `ser_clk` shifts `ser_da` into the word. The first bit sent ends up at bit0 and the eleventh at bit10.
- R2: While `ser_clk` rests high, the selects decode the shifted word, and a 1 bit selects its capacitor.
- R3: While `ser_clk` is low (which is also the state of a disconnected pin), the selects decode the inverted stored word, so a stored 0 selects its capacitor.
- R4: With `variant`=1, the fields are coarse = bits 10..8, mid = bits 7..4 and fine = {0, bits 3..1}. Each field is binary weighted with the higher bit more significant.
- R5: With `variant`=0, mid = bits 8..5 and fine = bits 4..1. Coarse reads 0, and bits 0, 9 and 10 have no effect.
- R6: A qualifying pulse taken while the shifted word is all ones erases the stored word. Afterwards bits 10..1 are 1 and check bit0 is 0.
- R7: A qualifying pulse taken while exactly one shifted bit is 0 clears that stored bit. A pulse taken with two or more zero bits leaves the stored word unchanged.
- R8: A `pv_pulse` high for fewer than MIN_PULSE block clock cycles has no effect on the stored word.
- R9: With `ser_clk` and `ser_da` both high, no pulse, and exactly one shifted bit 0, `pv_read` equals the stored value of that bit.
- R10: After reset, the shifted word is all zero, the stored word holds the erased value, and `pv_read` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock that samples the serial lines |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_da | input | 1 | Serial data line |
| ser_clk | input | 1 | Serial clock line; its resting level picks the select source |
| pv_pulse | input | 1 | High while a programming pulse is applied |
| variant | input | 1 | 1 = three-field decode, 0 = reduced decode |
| coarse_sel | output | 3 | Coarse capacitor select field |
| mid_sel | output | 4 | Mid capacitor select field |
| fine_sel | output | 4 | Fine capacitor select field |
| pv_read | output | 1 | Readback level of the selected stored bit |

## Verification
Words with distinct values in each field are shifted in under both variants. An asymmetric word exposes a reversed shift order or a misplaced field boundary. A word whose bits 0, 9 and 10 differ from its neighbours shows whether the reduced decode really ignores them.

The store is then driven with several pulse patterns: a single zero, two zeros, all ones, and a single zero with a pulse that is too short. Each of these is observed through the decoded selects with the clock line low. Readback of a cleared bit and of a set bit distinguishes a correct bit index from a constant or inverted level.

// File: rtl/trim_pkg.sv
// Shared widths and constants for the serial capacitor trim logic.
// Assumes the fixed 11-bit word layout that the field decode depends on.
package trim_pkg;
    localparam int WORD_W   = 11;
    localparam int COARSE_W = 3;
    localparam int MID_W    = 4;
    localparam int FINE_W   = 4;
    localparam int IDX_W    = $clog2(WORD_W);
    localparam int CNTZ_W   = $clog2(WORD_W + 1);

    typedef logic [WORD_W-1:0] word_t;

    // Erased store: every capacitor bit high, check bit0 low
    localparam word_t ERASED_WORD = {{(WORD_W-1){1'b1}}, 1'b0};
endpackage

// File: rtl/trim_shifter.sv
// Samples the serial lines with the block clock and shifts the data line
// into an 11-bit word on each rising edge of the serial clock line.
// Assumes ser_da and ser_clk are already synchronous to clk.
module trim_shifter
    import trim_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  ser_da,
    input  logic  ser_clk,
    output logic  clk_lvl,
    output logic  da_lvl,
    output word_t shreg
);
    logic rise;

    // Rising edge of the serial clock relative to its last sampled level
    assign rise = ser_clk && !clk_lvl;

    // Sample the line levels once per block clock
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clk_lvl <= 1'b0;
            da_lvl  <= 1'b0;
        end else begin
            clk_lvl <= ser_clk;
            da_lvl  <= ser_da;
        end
    end

    // Shift toward bit0 so the first bit sent settles at bit0
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= '0;
        end else if (rise) begin
            shreg <= {ser_da, shreg[WORD_W-1:1]};
        end
    end

    // R1
    shift_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> (shreg[WORD_W-1] == $past(ser_da)) && (shreg[WORD_W-2:0] == $past(shreg[WORD_W-1:1])));

    // R1
    shift_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rise |=> $stable(shreg));
endmodule

// File: rtl/trim_store.sv
// Model of the nonvolatile select word. It acts on programming pulses of at
// least MIN_PULSE cycles, according to the shifted word, and drives the
// readback level.
// Assumes pv_pulse is synchronous to clk; the stored word resets to erased.
module trim_store
    import trim_pkg::*;
#(
    parameter int MIN_PULSE = 4
)(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  pv_pulse,
    input  word_t shreg,
    input  logic  clk_lvl,
    input  logic  da_lvl,
    output word_t store,
    output logic  pv_read
);
    localparam int CNT_W = $clog2(MIN_PULSE + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MIN_PULSE);

    logic [CNT_W-1:0]  plen;
    logic              pv_q;
    logic              pulse_end;
    logic              pulse_ok;
    logic [CNTZ_W-1:0] zero_cnt;
    logic [IDX_W-1:0]  zero_idx;
    logic              one_zero;
    logic              all_ones;

    // Count pulse length, saturating at the qualifying minimum
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            plen <= '0;
            pv_q <= 1'b0;
        end else begin
            pv_q <= pv_pulse;
            if (!pv_pulse)
                plen <= '0;
            else if (plen != CNT_MAX)
                plen <= plen + 1'b1;
        end
    end

    assign pulse_end = pv_q && !pv_pulse;
    assign pulse_ok  = pulse_end && (plen == CNT_MAX);

    // Count zero bits in the shifted word and locate the last one found
    always_comb begin
        zero_cnt = '0;
        zero_idx = '0;
        for (int i = 0; i < WORD_W; i++) begin
            if (!shreg[i]) begin
                zero_cnt = zero_cnt + 1'b1;
                zero_idx = IDX_W'(i);
            end
        end
    end

    assign one_zero = (zero_cnt == CNTZ_W'(1));
    assign all_ones = (zero_cnt == '0);

    // Apply erase or single-bit clear when a qualifying pulse ends
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            store <= ERASED_WORD;
        end else if (pulse_ok) begin
            if (all_ones)
                store <= ERASED_WORD;
            else if (one_zero)
                store[zero_idx] <= 1'b0;
        end
    end

    // Readback of the selected stored bit while both lines rest high
    assign pv_read = clk_lvl && da_lvl && !pv_pulse && one_zero && store[zero_idx];

    // R8
    short_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse_end && (plen != CNT_MAX)) |=> $stable(store));

    // R7
    pulse_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pv_pulse |=> $stable(store));

    // R6
    erase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse_ok && (shreg == '1)) |=> (store == ERASED_WORD));

    // R7
    write_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse_ok && ($countones(shreg) == WORD_W - 1)) |=>
            ($countones(store) <= $countones($past(store))));

    // R9
    read_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pv_read |-> (clk_lvl && da_lvl && !pv_pulse));
endmodule

// File: rtl/trim_decode.sv
// Chooses the select source from the resting serial clock level and splits
// the word into coarse, mid and fine fields for the chosen variant.
// Assumes the stored word is active low and the shifted word active high.
module trim_decode
    import trim_pkg::*;
(
    input  logic                clk_lvl,
    input  logic                variant,
    input  word_t               shreg,
    input  word_t               store,
    output logic [COARSE_W-1:0] coarse_sel,
    output logic [MID_W-1:0]    mid_sel,
    output logic [FINE_W-1:0]   fine_sel
);
    word_t act;

    // Source select: shifted word when clock rests high, inverted store otherwise
    assign act = clk_lvl ? shreg : ~store;

    // Field split per variant
    always_comb begin
        if (variant) begin
            coarse_sel = act[10:8];
            mid_sel    = act[7:4];
            fine_sel   = {1'b0, act[3:1]};
        end else begin
            coarse_sel = '0;
            mid_sel    = act[8:5];
            fine_sel   = act[4:1];
        end
    end
endmodule

// File: rtl/trim_ctrl.sv
// Top of the serial capacitor trim logic: the shifter, the nonvolatile
// store model and the select decode.
// Assumes all inputs are synchronous to clk; a disconnected pin reads 0.
module trim_ctrl
    import trim_pkg::*;
#(
    parameter int MIN_PULSE = 4
)(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ser_da,
    input  logic                ser_clk,
    input  logic                pv_pulse,
    input  logic                variant,
    output logic [COARSE_W-1:0] coarse_sel,
    output logic [MID_W-1:0]    mid_sel,
    output logic [FINE_W-1:0]   fine_sel,
    output logic                pv_read
);
    logic  clk_lvl;
    logic  da_lvl;
    word_t shreg;
    word_t store;

    trim_shifter u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .ser_da  (ser_da),
        .ser_clk (ser_clk),
        .clk_lvl (clk_lvl),
        .da_lvl  (da_lvl),
        .shreg   (shreg)
    );

    trim_store #(.MIN_PULSE(MIN_PULSE)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .pv_pulse (pv_pulse),
        .shreg    (shreg),
        .clk_lvl  (clk_lvl),
        .da_lvl   (da_lvl),
        .store    (store),
        .pv_read  (pv_read)
    );

    trim_decode u_dec (
        .clk_lvl    (clk_lvl),
        .variant    (variant),
        .shreg      (shreg),
        .store      (store),
        .coarse_sel (coarse_sel),
        .mid_sel    (mid_sel),
        .fine_sel   (fine_sel)
    );

    // R10
    reset_state_chk: assert property (@(posedge clk)
        $past(!rst_n) |-> (store == ERASED_WORD) && (shreg == '0) && !pv_read);
endmodule

// File: tb/sim_trim_ctrl.sv
module sim_trim_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 5;

    typedef struct packed {
        logic        var_full;
        logic [10:0] word;
        logic [2:0]  e_coarse;
        logic [3:0]  e_mid;
        logic [3:0]  e_fine;
    } vec_t;

    localparam vec_t VECS [NVEC] = '{
        '{1'b1, 11'b101_0110_011_1, 3'd5, 4'd6,  4'd3},
        '{1'b1, 11'b111_1111_111_0, 3'd7, 4'd15, 4'd7},
        '{1'b0, 11'b1_0_1101_0010_1, 3'd0, 4'd13, 4'd2},
        '{1'b1, 11'b000_0000_000_0, 3'd0, 4'd0,  4'd0},
        '{1'b0, 11'b0_1_0000_1111_0, 3'd0, 4'd0,  4'd15}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_da = 1'b0;
    logic ser_clk = 1'b0;
    logic pv_pulse = 1'b0;
    logic variant = 1'b1;
    logic [2:0] coarse_sel;
    logic [3:0] mid_sel;
    logic [3:0] fine_sel;
    logic pv_read;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    trim_ctrl u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .ser_da     (ser_da),
        .ser_clk    (ser_clk),
        .pv_pulse   (pv_pulse),
        .variant    (variant),
        .coarse_sel (coarse_sel),
        .mid_sel    (mid_sel),
        .fine_sel   (fine_sel),
        .pv_read    (pv_read)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic check_sel(input string req, input int c, input int m, input int f);
        check(req, coarse_sel, c);
        check(req, mid_sel, m);
        check(req, fine_sel, f);
    endtask

    // Send bit0 first; leaves ser_clk resting high
    task automatic send_word(input logic [10:0] w);
        for (int i = 0; i < 11; i++) begin
            @(negedge clk); ser_clk = 1'b0; ser_da = w[i];
            @(negedge clk);
            @(negedge clk); ser_clk = 1'b1;
            @(negedge clk);
        end
        @(negedge clk);
    endtask

    task automatic clk_low();
        @(negedge clk); ser_clk = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic pulse(input int n);
        @(negedge clk); pv_pulse = 1'b1;
        for (int i = 0; i < n; i++) @(negedge clk);
        pv_pulse = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R10: reset state; clock low shows erased store -> nothing selected
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_sel("R10 reset selects", 0, 0, 0);
        check("R10 reset pv_read", pv_read, 0);

        // R1 R2 R4 R5: vector table, shifted word drives selects while clock high
        for (int k = 0; k < NVEC; k++) begin
            variant = VECS[k].var_full;
            send_word(VECS[k].word);
            check_sel($sformatf("R1 R2 R4 R5 vec%0d", k),
                      VECS[k].e_coarse, VECS[k].e_mid, VECS[k].e_fine);
        end

        // R3: clock low, erased store selects nothing despite a loaded word
        variant = 1'b1;
        clk_low();
        check_sel("R3 store source", 0, 0, 0);

        // R7: single zero at bit2 programs stored bit2
        send_word(11'b111_1111_1011);
        pulse(4);
        clk_low();
        check_sel("R7 write bit2", 0, 0, 2);

        // R8: short pulse with bit5 zero leaves store unchanged
        send_word(11'b111_1101_1111);
        pulse(2);
        clk_low();
        check_sel("R8 short pulse", 0, 0, 2);

        // R9: readback of cleared bit2 and still-set bit3
        send_word(11'b111_1111_1011);
        check("R9 read bit2", pv_read, 0);
        send_word(11'b111_1111_0111);
        check("R9 read bit3", pv_read, 1);

        // R7: two zeros give no write
        send_word(11'b111_1100_1111);
        pulse(4);
        clk_low();
        check_sel("R7 two zeros", 0, 0, 2);

        // R6: erase, then check selects and readback of bit0 and bit1
        send_word(11'b111_1111_1111);
        pulse(4);
        clk_low();
        check_sel("R6 erase", 0, 0, 0);
        send_word(11'b111_1111_1110);
        check("R6 check bit0", pv_read, 0);
        send_word(11'b111_1111_1101);
        check("R6 bit1 high", pv_read, 1);

        // R5 R4: stored bit8 seen through both decodes
        send_word(11'b110_1111_1111);
        pulse(4);
        variant = 1'b0;
        clk_low();
        check_sel("R5 stored bit8", 0, 8, 0);
        variant = 1'b1;
        @(negedge clk);
        check_sel("R4 stored bit8", 1, 0, 0);

        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule